// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Reservation Tracker

This block sits beside the execute stage of a single hart and decides whether a word-sized store-conditional may reach memory. A load-reserved operation reads a word and records a reservation on its word address. A later store-conditional is forwarded to memory only if that reservation is still live and covers the same word. Its outcome goes back to the register file as a completion code.

The reservation can be lost in several ways, and every one of them makes a later store-conditional fail without touching memory. A store-conditional consumes the reservation, whether it succeeds or fails. A trap or return-from-trap pulse drops it. A snooped store from another agent to the reserved word drops it. A lifetime counter also retires it once too many instructions have retired since it was set. Plain stores from this hart pass straight through. Memory sits outside the block and answers reads combinationally on `mem_rdata`. All request and result outputs are combinational from the current operation, and the reservation state updates on the clock edge.

Top module: `lrsc_resv_unit`

## Requirements
- R1: An aligned load-reserved (`op_kind` = 2'b01) issues a read at `rs1_addr`, returns `mem_rdata` on `rf_value` with `rf_we` high and `rf_idx` = `rd_idx`, and records a reservation on that word.
- R2: An aligned store-conditional (`op_kind` = 2'b10) writes `rs2_data` to `rs1_addr` (`mem_en` and `mem_we` high) when a live reservation exists on the same word.
- R3: A store-conditional writes its completion code to `rf_value`: 0 on success and 1 on failure.
- R4: Every aligned store-conditional clears the reservation, so a second store-conditional to the same word fails.
- R5: A store-conditional without a matching live reservation raises neither `mem_en` nor `mem_we`, and the stored word stays unchanged. This includes a store-conditional to a different word than the reserved one.
- R6: Reservation matching compares word addresses only, so address bits [1:0] of a snooped store are ignored.
- R7: A `trap_clr` pulse clears the reservation, and it takes priority over a load-reserved issued in the same cycle.
- R8: With `rd_idx` = 0, `rf_we` stays low, while the memory request is the same as for a nonzero index.
- R9: A load-reserved or store-conditional with `rs1_addr[1:0]` nonzero raises `misaligned`, issues no memory request and no register write, and leaves the reservation unchanged.
- R10: A snooped store (`snoop_valid`) to the reserved word clears the reservation in the same cycle, so a store-conditional in that cycle fails. A snooped store to another word has no effect.
- R11: A load-reserved issued while a reservation is held replaces the reserved word and restarts the lifetime count.
- R12: The lifetime counts `instr_retire` cycles after the load-reserved. A store-conditional after 15 such cycles succeeds, and one after 16 fails.
- R13: A plain store (`op_kind` = 2'b11) is written unconditionally and leaves the reservation unaffected.
- R14: After reset no reservation is held and all request outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present this cycle |
| op_kind | input | 2 | 00 none, 01 load-reserved, 10 store-conditional, 11 plain store |
| rs1_addr | input | AW | Byte address |
| rs2_data | input | DW | Store data |
| rd_idx | input | 5 | Destination register index |
| instr_retire | input | 1 | An instruction retires this cycle |
| trap_clr | input | 1 | Trap entry or trap return pulse |
| snoop_valid | input | 1 | Store by another agent observed |
| snoop_addr | input | AW | Byte address of the snooped store |
| mem_rdata | input | DW | Read data for the current request |
| mem_en | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Request address |
| mem_wdata | output | DW | Write data |
| rf_we | output | 1 | Register-file write enable |
| rf_idx | output | 5 | Register-file write index |
| rf_value | output | DW | Loaded word or completion code |
| misaligned | output | 1 | Misaligned reserved access |

## Verification
The bench builds the block with its default widths (32-bit address and data) and a lifetime bound of 16. With this bound both sides of the expiry edge can be reached within a few dozen cycles: 15 retired instructions still allow success, and 16 force failure. Its memory model of 16 words lets a word left untouched by a failed store-conditional be read back with a later load-reserved.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;

    typedef enum logic [1:0] {
        OPK_NONE = 2'b00,
        OPK_LR   = 2'b01,
        OPK_SC   = 2'b10,
        OPK_ST   = 2'b11
    } opk_e;

    // Commands from the decoder to the reservation holder
    typedef struct packed {
        logic set;      // aligned load-reserved
        logic consume;  // aligned store-conditional
    } resv_cmd_t;

    localparam logic SC_CODE_PASS = 1'b0;
    localparam logic SC_CODE_FAIL = 1'b1;

    function automatic logic is_misaligned(input logic [1:0] low);
        return |low;
    endfunction

endpackage

// File: rtl/lrsc_op_decode.sv
module lrsc_op_decode
    import lrsc_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int RW = 5
) (
    input  logic          op_valid,
    input  opk_e          op_kind,
    input  logic [AW-1:0] rs1_addr,
    input  logic [DW-1:0] rs2_data,
    input  logic [RW-1:0] rd_idx,
    input  logic [DW-1:0] mem_rdata,
    input  logic          live,
    input  logic [AW-3:0] resv_word,
    output logic          mem_en,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          rf_we,
    output logic [RW-1:0] rf_idx,
    output logic [DW-1:0] rf_value,
    output logic          misaligned,
    output resv_cmd_t     cmd
);

    logic is_lr, is_sc, is_st, bad_align, word_hit;

    assign is_lr     = op_valid && (op_kind == OPK_LR);
    assign is_sc     = op_valid && (op_kind == OPK_SC);
    assign is_st     = op_valid && (op_kind == OPK_ST);
    assign bad_align = (is_lr || is_sc) && is_misaligned(rs1_addr[1:0]);
    assign word_hit  = live && ((rs1_addr & ~AW'(3)) == {resv_word, 2'b00});

    always_comb begin
        mem_en     = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = '0;
        mem_wdata  = '0;
        rf_we      = 1'b0;
        rf_idx     = rd_idx;
        rf_value   = '0;
        misaligned = bad_align;
        cmd        = '0;
        if (is_lr && !bad_align) begin
            mem_en   = 1'b1;
            mem_addr = rs1_addr;
            rf_we    = (rd_idx != '0);
            rf_value = mem_rdata;
            cmd.set  = 1'b1;
        end else if (is_sc && !bad_align) begin
            cmd.consume = 1'b1;
            rf_we       = (rd_idx != '0);
            rf_value    = {{(DW-1){1'b0}}, (word_hit ? SC_CODE_PASS : SC_CODE_FAIL)};
            if (word_hit) begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = rs1_addr;
                mem_wdata = rs2_data;
            end
        end else if (is_st) begin
            mem_en    = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = rs1_addr;
            mem_wdata = rs2_data;
        end
    end

endmodule

// File: rtl/lrsc_resv_hold.sv
module lrsc_resv_hold
    import lrsc_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  resv_cmd_t     cmd,
    input  logic [AW-1:0] req_addr,
    input  logic          trap_clr,
    input  logic          snoop_valid,
    input  logic [AW-1:0] snoop_addr,
    input  logic          expire,
    output logic          valid_q,
    output logic [AW-3:0] word_q,
    output logic          kill,
    output logic          live
);

    logic snoop_hit;

    assign snoop_hit = valid_q && snoop_valid &&
                       ((snoop_addr & ~AW'(3)) == {word_q, 2'b00});
    assign kill = trap_clr || snoop_hit;
    assign live = valid_q && !kill;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            word_q  <= '0;
        end else if (kill) begin
            valid_q <= 1'b0;
        end else if (cmd.set) begin
            valid_q <= 1'b1;
            word_q  <= req_addr[AW-1:2];
        end else if (cmd.consume || expire) begin
            valid_q <= 1'b0;
        end
    end

endmodule

// File: rtl/lrsc_lifetime.sv
module lrsc_lifetime #(
    parameter int LIFE_LIMIT = 16,
    localparam int CW = $clog2(LIFE_LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          held,
    input  logic          retire,
    input  logic          restart,
    output logic          expire,
    output logic [CW-1:0] count
);

    logic at_last;

    assign at_last = (count == CW'(LIFE_LIMIT - 1));
    assign expire  = held && retire && at_last && !restart;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            count <= '0;
        end else if (held && retire) begin
            count <= at_last ? '0 : count + 1'b1;
        end
    end

endmodule

// File: rtl/lrsc_resv_unit.sv
module lrsc_resv_unit
    import lrsc_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int LIFE_LIMIT = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          op_valid,
    input  logic [1:0]    op_kind,
    input  logic [AW-1:0] rs1_addr,
    input  logic [DW-1:0] rs2_data,
    input  logic [4:0]    rd_idx,
    input  logic          instr_retire,
    input  logic          trap_clr,
    input  logic          snoop_valid,
    input  logic [AW-1:0] snoop_addr,
    input  logic [DW-1:0] mem_rdata,
    output logic          mem_en,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          rf_we,
    output logic [4:0]    rf_idx,
    output logic [DW-1:0] rf_value,
    output logic          misaligned
);

    localparam int CW = $clog2(LIFE_LIMIT + 1);

    resv_cmd_t     cmd;
    logic          resv_valid;
    logic [AW-3:0] resv_word;
    logic          kill;
    logic          live;
    logic          expire;
    logic [CW-1:0] life_cnt;

    lrsc_op_decode #(.AW(AW), .DW(DW), .RW(5)) u_decode (
        .op_valid   (op_valid),
        .op_kind    (opk_e'(op_kind)),
        .rs1_addr   (rs1_addr),
        .rs2_data   (rs2_data),
        .rd_idx     (rd_idx),
        .mem_rdata  (mem_rdata),
        .live       (live),
        .resv_word  (resv_word),
        .mem_en     (mem_en),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .rf_we      (rf_we),
        .rf_idx     (rf_idx),
        .rf_value   (rf_value),
        .misaligned (misaligned),
        .cmd        (cmd)
    );

    lrsc_resv_hold #(.AW(AW)) u_hold (
        .clk         (clk),
        .rst         (rst),
        .cmd         (cmd),
        .req_addr    (rs1_addr),
        .trap_clr    (trap_clr),
        .snoop_valid (snoop_valid),
        .snoop_addr  (snoop_addr),
        .expire      (expire),
        .valid_q     (resv_valid),
        .word_q      (resv_word),
        .kill        (kill),
        .live        (live)
    );

    lrsc_lifetime #(.LIFE_LIMIT(LIFE_LIMIT)) u_life (
        .clk     (clk),
        .rst     (rst),
        .held    (resv_valid),
        .retire  (instr_retire),
        .restart (kill || cmd.set || cmd.consume),
        .expire  (expire),
        .count   (life_cnt)
    );

endmodule

// File: rtl/lrsc_resv_chk.sv
module lrsc_resv_chk #(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int LIFE_LIMIT = 16,
    localparam int CW = $clog2(LIFE_LIMIT + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          op_valid,
    input logic [1:0]    op_kind,
    input logic [AW-1:0] rs1_addr,
    input logic [4:0]    rd_idx,
    input logic          trap_clr,
    input logic          snoop_valid,
    input logic          mem_en,
    input logic          mem_we,
    input logic          rf_we,
    input logic [DW-1:0] rf_value,
    input logic          misaligned,
    input logic          resv_valid,
    input logic [AW-3:0] resv_word,
    input logic [CW-1:0] life_cnt
);

    logic sc_ok_align, lr_ok_align;
    assign sc_ok_align = op_valid && (op_kind == 2'b10) && !misaligned;
    assign lr_ok_align = op_valid && (op_kind == 2'b01) && !misaligned;

    AST_LR_RECORDS: assert property (@(posedge clk) disable iff (rst)
        (lr_ok_align && !trap_clr && !snoop_valid)
        |=> (resv_valid && resv_word == $past(rs1_addr[AW-1:2]))); // R1

    AST_SC_CODE_MATCHES_WRITE: assert property (@(posedge clk) disable iff (rst)
        (sc_ok_align && rd_idx != 5'd0)
        |-> (rf_we && (mem_we == (rf_value == '0)))); // R3

    AST_SC_CONSUMES: assert property (@(posedge clk) disable iff (rst)
        sc_ok_align |=> !resv_valid); // R4

    AST_SC_NO_RESV_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_kind == 2'b10 && !resv_valid) |-> !mem_we); // R5

    AST_TRAP_CLEARS: assert property (@(posedge clk) disable iff (rst)
        trap_clr |=> !resv_valid); // R7

    AST_RD0_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (rd_idx == 5'd0) |-> !rf_we); // R8

    AST_MISALIGN_QUIET: assert property (@(posedge clk) disable iff (rst)
        misaligned |-> (!mem_en && !rf_we)); // R9

    AST_MISALIGN_KEEPS_WORD: assert property (@(posedge clk) disable iff (rst)
        misaligned |=> $stable(resv_word)); // R9

    AST_LIFE_BOUND: assert property (@(posedge clk) disable iff (rst)
        resv_valid |-> (int'(life_cnt) < LIFE_LIMIT)); // R12

endmodule

bind lrsc_resv_unit lrsc_resv_chk #(
    .AW(AW), .DW(DW), .LIFE_LIMIT(LIFE_LIMIT)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .op_valid    (op_valid),
    .op_kind     (op_kind),
    .rs1_addr    (rs1_addr),
    .rd_idx      (rd_idx),
    .trap_clr    (trap_clr),
    .snoop_valid (snoop_valid),
    .mem_en      (mem_en),
    .mem_we      (mem_we),
    .rf_we       (rf_we),
    .rf_value    (rf_value),
    .misaligned  (misaligned),
    .resv_valid  (resv_valid),
    .resv_word   (resv_word),
    .life_cnt    (life_cnt)
);

// File: tb/lrsc_resv_unit_tb.sv
module lrsc_resv_unit_tb;

    localparam int CLK_PERIOD = 10;
    localparam int LIMIT = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [1:0]  op_kind = 2'b00;
    logic [31:0] rs1_addr = '0;
    logic [31:0] rs2_data = '0;
    logic [4:0]  rd_idx = '0;
    logic        instr_retire = 1'b0;
    logic        trap_clr = 1'b0;
    logic        snoop_valid = 1'b0;
    logic [31:0] snoop_addr = '0;
    logic [31:0] mem_rdata;
    logic        mem_en, mem_we, rf_we, misaligned;
    logic [31:0] mem_addr, mem_wdata, rf_value;
    logic [4:0]  rf_idx;

    always #(CLK_PERIOD/2) clk = ~clk;

    lrsc_resv_unit u_dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_kind(op_kind),
        .rs1_addr(rs1_addr), .rs2_data(rs2_data), .rd_idx(rd_idx),
        .instr_retire(instr_retire), .trap_clr(trap_clr),
        .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
        .mem_rdata(mem_rdata), .mem_en(mem_en), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .rf_we(rf_we),
        .rf_idx(rf_idx), .rf_value(rf_value), .misaligned(misaligned)
    );

    // Memory seen by the block, and the bench's expected copy of it
    logic [31:0] mem     [16];
    logic [31:0] exp_mem [16];
    initial for (int i = 0; i < 16; i++) begin
        mem[i]     = 32'hC0DE_0000 + 32'(i * 17);
        exp_mem[i] = 32'hC0DE_0000 + 32'(i * 17);
    end
    assign mem_rdata = mem[mem_addr[5:2]];
    always @(posedge clk) if (mem_en && mem_we) mem[mem_addr[5:2]] <= mem_wdata;

    typedef struct {
        logic        en, we;
        logic [31:0] addr, wdata;
        logic        rwe;
        logic [4:0]  ridx;
        logic [31:0] rval;
        logic        mis;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail = 0;

    // Reference reservation model
    logic        m_valid = 1'b0;
    logic [29:0] m_word  = '0;
    int          m_cnt   = 0;

    task automatic drive(input logic [1:0] k, input logic [31:0] a,
                         input logic [31:0] d, input logic [4:0] rd,
                         input logic tr, input logic sv, input logic [31:0] sa,
                         input string tag);
        exp_t e;
        logic kill, live, mis, ok;
        @(posedge clk); #1;
        op_valid = (k != 2'b00); op_kind = k; rs1_addr = a; rs2_data = d;
        rd_idx = rd; instr_retire = 1'b1; trap_clr = tr;
        snoop_valid = sv; snoop_addr = sa;
        kill = tr || (sv && m_valid && sa[31:2] == m_word);
        live = m_valid && !kill;
        mis  = (k == 2'b01 || k == 2'b10) && (a[1:0] != 2'b00);
        e = '{en:1'b0, we:1'b0, addr:'0, wdata:'0, rwe:1'b0, ridx:rd,
              rval:'0, mis:mis, tag:tag};
        ok = 1'b0;
        if (k == 2'b01 && !mis) begin
            e.en = 1'b1; e.addr = a; e.rwe = (rd != 0); e.rval = exp_mem[a[5:2]];
        end else if (k == 2'b10 && !mis) begin
            ok = live && (a[31:2] == m_word);
            e.rwe = (rd != 0); e.rval = ok ? 32'd0 : 32'd1;
            if (ok) begin
                e.en = 1'b1; e.we = 1'b1; e.addr = a; e.wdata = d;
                exp_mem[a[5:2]] = d;
            end
        end else if (k == 2'b11) begin
            e.en = 1'b1; e.we = 1'b1; e.addr = a; e.wdata = d;
            exp_mem[a[5:2]] = d;
        end
        exp_q.push_back(e);
        // model next state
        if (kill) begin
            m_valid = 1'b0; m_cnt = 0;
        end else if (k == 2'b01 && !mis) begin
            m_valid = 1'b1; m_word = a[31:2]; m_cnt = 0;
        end else if (k == 2'b10 && !mis) begin
            m_valid = 1'b0; m_cnt = 0;
        end else if (m_valid) begin
            m_cnt = m_cnt + 1;
            if (m_cnt == LIMIT) begin
                m_valid = 1'b0; m_cnt = 0;
            end
        end
    endtask

    task automatic op(input logic [1:0] k, input logic [31:0] a,
                      input logic [31:0] d, input logic [4:0] rd, input string tag);
        drive(k, a, d, rd, 1'b0, 1'b0, 32'd0, tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) drive(2'b00, 32'd0, 32'd0, 5'd0, 1'b0, 1'b0, 32'd0, tag);
    endtask

    // Monitor: compare each cycle's outputs with the queued expectation
    always @(negedge clk) begin
        if (!rst && exp_q.size() > 0) begin
            exp_t e;
            logic good;
            e = exp_q.pop_front();
            good = (mem_en === e.en) && (mem_we === e.we) && (misaligned === e.mis)
                && (rf_we === e.rwe);
            if (e.en)  good = good && (mem_addr === e.addr);
            if (e.we)  good = good && (mem_wdata === e.wdata);
            if (e.rwe) good = good && (rf_value === e.rval) && (rf_idx === e.ridx);
            n_checks++;
            if (!good) begin
                n_fail++;
                $display("FAIL %s: got en=%b we=%b addr=%h wd=%h rwe=%b idx=%0d val=%h mis=%b exp en=%b we=%b addr=%h wd=%h rwe=%b idx=%0d val=%h mis=%b",
                    e.tag, mem_en, mem_we, mem_addr, mem_wdata, rf_we, rf_idx, rf_value, misaligned,
                    e.en, e.we, e.addr, e.wdata, e.rwe, e.ridx, e.rval, e.mis);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        n_checks++;
        if (mem_en !== 1'b0 || rf_we !== 1'b0 || misaligned !== 1'b0) begin
            n_fail++;
            $display("FAIL R14: got en=%b rwe=%b mis=%b expected 0 0 0", mem_en, rf_we, misaligned);
        end
        op(2'b10, 32'h10, 32'hDEAD0001, 5'd3, "R14 no reservation after reset");

        op(2'b01, 32'h10, 32'd0, 5'd5, "R1 lr read");
        op(2'b10, 32'h10, 32'hAAAA0001, 5'd6, "R2 R3 sc success");
        op(2'b10, 32'h10, 32'hAAAA0002, 5'd6, "R4 second sc fails");
        op(2'b01, 32'h10, 32'd0, 5'd5, "R4 memory holds first sc data");

        op(2'b01, 32'h20, 32'd0, 5'd7, "R7 lr before trap");
        drive(2'b00, 32'd0, 32'd0, 5'd0, 1'b1, 1'b0, 32'd0, "R7 trap pulse");
        op(2'b10, 32'h20, 32'hBBBB0000, 5'd8, "R7 R5 sc after trap fails");
        op(2'b01, 32'h20, 32'd0, 5'd9, "R5 word unchanged");
        drive(2'b01, 32'h24, 32'd0, 5'd9, 1'b1, 1'b0, 32'd0, "R7 trap with lr");
        op(2'b10, 32'h24, 32'hBBBB0001, 5'd8, "R7 clear wins over lr");

        op(2'b01, 32'h30, 32'd0, 5'd1, "R5 lr");
        op(2'b10, 32'h34, 32'hCCCC0000, 5'd2, "R5 sc other word fails");
        op(2'b10, 32'h30, 32'hCCCC0001, 5'd2, "R4 sc after failed sc fails");
        op(2'b01, 32'h34, 32'd0, 5'd2, "R5 other word unchanged");

        op(2'b01, 32'h10, 32'd0, 5'd0, "R8 lr rd0");
        op(2'b10, 32'h10, 32'hDDDD0000, 5'd0, "R8 sc rd0 still writes");
        op(2'b01, 32'h10, 32'd0, 5'd4, "R8 memory written");

        op(2'b01, 32'h10, 32'd0, 5'd4, "R9 lr");
        op(2'b01, 32'h15, 32'd0, 5'd4, "R9 misaligned lr");
        op(2'b10, 32'h12, 32'hEEEE0000, 5'd4, "R9 misaligned sc");
        op(2'b10, 32'h10, 32'hEEEE0001, 5'd4, "R9 reservation kept");

        op(2'b01, 32'h18, 32'd0, 5'd10, "R10 lr");
        drive(2'b00, 32'd0, 32'd0, 5'd0, 1'b0, 1'b1, 32'h1C, "R10 snoop other word");
        op(2'b10, 32'h18, 32'hF0000001, 5'd10, "R10 sc after foreign snoop ok");
        op(2'b01, 32'h18, 32'd0, 5'd10, "R6 lr");
        drive(2'b00, 32'd0, 32'd0, 5'd0, 1'b0, 1'b1, 32'h1A, "R6 snoop low bits set");
        op(2'b10, 32'h18, 32'hF0000002, 5'd10, "R6 R10 sc after hit fails");
        op(2'b01, 32'h18, 32'd0, 5'd10, "R10 lr");
        drive(2'b10, 32'h18, 32'hF0000003, 5'd10, 1'b0, 1'b1, 32'h18, "R10 snoop same cycle as sc");

        op(2'b01, 32'h10, 32'd0, 5'd11, "R11 lr first");
        op(2'b01, 32'h14, 32'd0, 5'd11, "R11 lr replace");
        op(2'b10, 32'h10, 32'h11110000, 5'd11, "R11 old word fails");
        op(2'b01, 32'h10, 32'd0, 5'd11, "R11 lr");
        idle(10, "R11 idle");
        op(2'b01, 32'h14, 32'd0, 5'd11, "R11 relr restarts");
        idle(15, "R11 idle");
        op(2'b10, 32'h14, 32'h11110001, 5'd11, "R11 R12 sc after restart ok");

        op(2'b01, 32'h28, 32'd0, 5'd12, "R12 lr");
        idle(15, "R12 idle");
        op(2'b10, 32'h28, 32'h22220000, 5'd12, "R12 sc at 15 ok");
        op(2'b01, 32'h28, 32'd0, 5'd12, "R12 lr");
        idle(16, "R12 idle");
        op(2'b10, 32'h28, 32'h22220001, 5'd12, "R12 sc at 16 fails");

        op(2'b01, 32'h10, 32'd0, 5'd13, "R13 lr");
        op(2'b11, 32'h14, 32'h33330000, 5'd0, "R13 plain store");
        op(2'b10, 32'h10, 32'h33330001, 5'd13, "R13 reservation survives store");
        op(2'b01, 32'h14, 32'd0, 5'd13, "R13 store landed");

        idle(2, "drain");
        @(negedge clk);
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule